// File: doc/BRIEF.md
# Self-Timed Byte-Wide EEPROM Controller

This block is a clocked, synthesizable model of the control logic inside a byte-wide parallel EEPROM. The host uses three active-low strobes: chip-enable, output-enable and write-enable. Reads behave like an asynchronous static RAM. A byte write takes its address when the strobe pair becomes active and its data when the pair goes inactive. After that the block runs by itself. It first erases the target byte to 0xFF. It then waits a programmable number of cycles and commits the byte. No further host action is needed. The tri-state data bus is shown as separate in, out and enable signals.

Two mechanisms report completion. The first is an open-drain ready/busy line, which the block pulls low for the whole write so that several devices can share one wired line. The second is data polling: while busy, any read returns the inverse of bit 7 of the pending byte. Writes are blocked when output-enable is low, when the supply-good flag is low, and during a power-on lockout after supply-good rises. A high-voltage identification flag maps a 32-byte side area onto the top 32 addresses. A high-voltage output-enable flag turns a long enough write pulse into a clear of the whole main array.

Top module: `eeprom_ctrl`

## Requirements
- R1: After the strobes pass a two-flop synchronizer, the block drives the bus (data_oe_o high) one cycle later only when chip-enable and output-enable are low and write-enable is high. In every other case data_oe_o is low.
- R2: A byte write is armed when both chip-enable and write-enable are low, whichever of the two falls last. The address is captured at that moment. The data is captured when either strobe rises.
- R3: Once the data is captured, the block is busy for exactly WR_CYC+1 cycles: one erase cycle that writes 0xFF, then WR_CYC programming cycles. After that, reads return the written byte on all bits.
- R4: While busy, a read at any address returns bit 7 equal to the inverse of bit 7 of the pending byte, with bits 6..0 at zero.
- R5: rdy_pull_lo_o is 1 (pulling the shared line low) exactly while a write or a clear is in progress. Otherwise it is 0 (released).
- R6: A write pulse made while output-enable is low changes no byte and causes no busy period.
- R7: No write starts while vdd_ok_i is low, or within PON_CYC cycles after vdd_ok_i rises.
- R8: A write strobe that arrives while the block is busy is ignored.
- R9: With hv_id_i set, addresses whose upper 8 bits are all ones (0x1FE0..0x1FFF) read and write a separate 32-byte area indexed by the low 5 address bits. All other addresses, and all addresses with hv_id_i clear, reach the main array.
- R10: With hv_oe_i set, a write-enable pulse of at least CLR_PULSE cycles sets every main-array byte to 0xFF, one byte per cycle, staying busy for 2^AW cycles. The identification area is left unchanged. A shorter pulse does nothing.
- R11: After reset the block is idle, the bus is released and ready/busy is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_ok_i | input | 1 | Supply-good flag |
| hv_id_i | input | 1 | High-voltage flag that selects the identification area |
| hv_oe_i | input | 1 | High-voltage flag on output-enable that selects chip clear |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Data bus, host to block |
| data_o | output | 8 | Data bus, block to host |
| data_oe_o | output | 1 | Bus drive enable |
| rdy_pull_lo_o | output | 1 | Open-drain ready/busy: 1 pulls the line low |

## Verification
The bench keeps the full 13-bit address width, so the identification window at the top of the space and a complete 8192-cycle chip clear are both exercised. It sets WR_CYC to 20 and PON_CYC to 50. With these values, a read issued right after a write always lands inside the busy window, and a write issued right after supply-good rises always lands inside the lockout. CLR_PULSE is 16, so clear pulses of 10 and 22 cycles fall on either side of the threshold. These values also let a second strobe be issued while the first write is still in progress.

// File: rtl/eeprom_ctrl_pkg.sv
package eeprom_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG, ST_CLRALL} wr_state_e;
  localparam int ID_AW = 5;
  localparam int DW    = 8;
endpackage

// File: rtl/eeprom_sync.sv
module eeprom_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eeprom_pon_timer.sv
module eeprom_pon_timer #(
  parameter int PON_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vdd_ok_i,
  output logic ok_o
);
  localparam int CW = $clog2(PON_CYC + 1) < 1 ? 1 : $clog2(PON_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!vdd_ok_i)                cnt_q <= '0;
    else if (cnt_q != CW'(PON_CYC))    cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = vdd_ok_i && (cnt_q == CW'(PON_CYC));
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eeprom_ctrl_pkg::*;
#(
  parameter int AW        = 13,
  parameter int WR_CYC    = 20,
  parameter int CLR_PULSE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_act_i,
  input  logic          oe_hi_i,
  input  logic          hv_oe_i,
  input  logic          hv_id_i,
  input  logic          allow_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          mem_we_o,
  output logic          id_we_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o,
  output logic          clr_o,
  output logic          poll_bit_o
);
  localparam int TW = $clog2(WR_CYC + 1) < 1 ? 1 : $clog2(WR_CYC + 1);
  localparam int PW = $clog2(CLR_PULSE + 1) < 1 ? 1 : $clog2(CLR_PULSE + 1);

  wr_state_e     state_q;
  logic          act_q, armed_q, clr_arm_q, id_q;
  logic [AW-1:0] a_q, ca_q;
  logic [DW-1:0] d_q;
  logic [TW-1:0] timer_q;
  logic [PW-1:0] pw_q;

  logic rise, fall, id_hit, pulse_ok, commit;
  assign rise     = wr_act_i && !act_q;
  assign fall     = !wr_act_i && act_q;
  assign id_hit   = hv_id_i && (&addr_i[AW-1:ID_AW]);
  assign pulse_ok = pw_q >= PW'(CLR_PULSE - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      act_q     <= 1'b0;
      armed_q   <= 1'b0;
      clr_arm_q <= 1'b0;
      id_q      <= 1'b0;
      a_q       <= '0;
      ca_q      <= '0;
      d_q       <= '0;
      timer_q   <= '0;
      pw_q      <= '0;
    end else begin
      act_q <= wr_act_i;
      unique case (state_q)
        ST_IDLE: begin
          if (rise && allow_i) begin
            if (hv_oe_i) begin
              clr_arm_q <= 1'b1;
              pw_q      <= '0;
            end else if (oe_hi_i) begin
              armed_q <= 1'b1;
              a_q     <= addr_i;
              id_q    <= id_hit;
            end
          end else if (clr_arm_q && wr_act_i && pw_q != PW'(CLR_PULSE)) begin
            pw_q <= pw_q + 1'b1;
          end
          if (fall) begin
            armed_q   <= 1'b0;
            clr_arm_q <= 1'b0;
            if (allow_i && armed_q) begin
              d_q     <= data_i;
              state_q <= ST_ERASE;
            end else if (allow_i && clr_arm_q && pulse_ok) begin
              d_q     <= '1;
              ca_q    <= '0;
              state_q <= ST_CLRALL;
            end
          end
        end
        ST_ERASE: begin
          timer_q <= TW'(WR_CYC - 1);
          state_q <= ST_PROG;
        end
        ST_PROG: begin
          if (timer_q == '0) state_q <= ST_IDLE;
          else               timer_q <= timer_q - 1'b1;
        end
        ST_CLRALL: begin
          if (&ca_q) state_q <= ST_IDLE;
          else       ca_q    <= ca_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // erase writes 0xFF, last programming cycle writes the latched byte
  assign commit     = (state_q == ST_ERASE) || (state_q == ST_PROG && timer_q == '0);
  assign mem_we_o   = (commit && !id_q) || (state_q == ST_CLRALL);
  assign id_we_o    = commit && id_q;
  assign wr_addr_o  = (state_q == ST_CLRALL) ? ca_q : a_q;
  assign wr_data_o  = (state_q == ST_ERASE || state_q == ST_CLRALL) ? '1 : d_q;
  assign busy_o     = state_q != ST_IDLE;
  assign clr_o      = state_q == ST_CLRALL;
  assign poll_bit_o = ~d_q[DW-1];
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_ctrl_pkg::*;
#(
  parameter int AW        = 13,
  parameter int WR_CYC    = 20,
  parameter int PON_CYC   = 50,
  parameter int CLR_PULSE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vdd_ok_i,
  input  logic          hv_id_i,
  input  logic          hv_oe_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_pull_lo_o
);
  localparam int DEPTH    = 2 ** AW;
  localparam int ID_DEPTH = 2 ** ID_AW;

  logic [2:0] strb_s;
  logic       ce_s, oe_s, we_s;

  eeprom_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, oe_ni, we_ni}),
    .q_o   (strb_s)
  );
  assign {ce_s, oe_s, we_s} = strb_s;

  logic allow;
  eeprom_pon_timer #(.PON_CYC(PON_CYC)) u_pon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vdd_ok_i(vdd_ok_i),
    .ok_o    (allow)
  );

  logic          mem_we, id_we, seq_busy, seq_clr, poll_bit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  eeprom_wr_seq #(.AW(AW), .WR_CYC(WR_CYC), .CLR_PULSE(CLR_PULSE)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_act_i  (!ce_s && !we_s),
    .oe_hi_i   (oe_s),
    .hv_oe_i   (hv_oe_i),
    .hv_id_i   (hv_id_i),
    .allow_i   (allow),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .mem_we_o  (mem_we),
    .id_we_o   (id_we),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .busy_o    (seq_busy),
    .clr_o     (seq_clr),
    .poll_bit_o(poll_bit)
  );

  logic [DW-1:0] main_mem [DEPTH];
  logic [DW-1:0] id_mem   [ID_DEPTH];
  logic [DW-1:0] rd_q;
  logic          oe_q, rd_id;

  assign rd_id = hv_id_i && (&addr_i[AW-1:ID_AW]);

  always_ff @(posedge clk_i) begin
    if (mem_we) main_mem[wr_addr] <= wr_data;
    if (id_we)  id_mem[wr_addr[ID_AW-1:0]] <= wr_data;
    rd_q <= rd_id ? id_mem[addr_i[ID_AW-1:0]] : main_mem[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= !ce_s && !oe_s && we_s;
  end

  always_comb begin
    data_o = '0;
    if (oe_q) data_o = seq_busy ? {poll_bit, {(DW-1){1'b0}}} : rd_q;
  end

  assign data_oe_o     = oe_q;
  assign rdy_pull_lo_o = seq_busy;
endmodule

// File: rtl/eeprom_ctrl_chk.sv
module eeprom_ctrl_chk #(
  parameter int AW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vdd_ok_i,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          we_ni,
  input logic [7:0]    data_o,
  input logic          data_oe_o,
  input logic          rdy_pull_lo_o,
  input logic          busy_i,
  input logic          clr_i,
  input logic [AW-1:0] wr_addr_i
);
  a_r1_drive_needs_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!$past(ce_ni, 3) && !$past(oe_ni, 3) && $past(we_ni, 3)));

  a_r4_poll_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && rdy_pull_lo_o) |-> (data_o[6:0] == 7'd0));

  a_r3_busy_lasts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_pull_lo_o) |=> rdy_pull_lo_o);

  a_r7_no_start_no_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vdd_ok_i && !rdy_pull_lo_o) |=> !rdy_pull_lo_o);

  a_r8_addr_held_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !clr_i) |-> $stable(wr_addr_i));

  a_r10_clear_walks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && $past(clr_i)) |-> (wr_addr_i == $past(wr_addr_i) + 1'b1));
endmodule

bind eeprom_ctrl eeprom_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vdd_ok_i     (vdd_ok_i),
  .ce_ni        (ce_ni),
  .oe_ni        (oe_ni),
  .we_ni        (we_ni),
  .data_o       (data_o),
  .data_oe_o    (data_oe_o),
  .rdy_pull_lo_o(rdy_pull_lo_o),
  .busy_i       (seq_busy),
  .clr_i        (seq_clr),
  .wr_addr_i    (wr_addr)
);

// File: tb/sim_eeprom_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_ctrl;
  localparam int AW   = 13;
  localparam int WR   = 20;
  localparam int PON  = 50;
  localparam int CLRP = 16;

  logic clk = 0, rst_n = 0;
  logic vdd_ok = 0, hv_id = 0, hv_oe = 0;
  logic ce = 1, oe = 1, we = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic doe, pull;

  eeprom_ctrl #(.AW(AW), .WR_CYC(WR), .PON_CYC(PON), .CLR_PULSE(CLRP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vdd_ok_i(vdd_ok), .hv_id_i(hv_id), .hv_oe_i(hv_oe),
    .ce_ni(ce), .oe_ni(oe), .we_ni(we), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .rdy_pull_lo_o(pull)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int run_len = 0, last_len = 0;
  bit busy_seen = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (pull) begin
      run_len   = run_len + 1;
      busy_seen = 1;
    end else if (run_len != 0) begin
      last_len = run_len;
      run_len  = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // mode 0: write-enable pulse, 1: chip-enable pulse with late data, 2: output-enable low
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int mode);
    @(negedge clk);
    if (mode == 1) begin
      addr = a; din = ~d; oe = 1; we = 0;
      repeat (2) @(negedge clk);
      ce = 0;
      repeat (4) @(negedge clk);
      addr = ~a; din = d;
      repeat (2) @(negedge clk);
      ce = 1;
      repeat (4) @(negedge clk);
      we = 1;
    end else begin
      addr = a; din = d; oe = (mode == 2) ? 1'b0 : 1'b1; ce = 0;
      repeat (2) @(negedge clk);
      we = 0;
      repeat (4) @(negedge clk);
      we = 1;
      repeat (4) @(negedge clk);
      ce = 1; oe = 1;
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
    @(negedge clk);
    addr = a; ce = 0; oe = 0; we = 1;
    repeat (5) @(negedge clk);
    v = dout; en = doe;
    ce = 1; oe = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_pulse(input int width);
    @(negedge clk);
    hv_oe = 1; oe = 1; ce = 0;
    repeat (2) @(negedge clk);
    we = 0;
    repeat (width) @(negedge clk);
    we = 1;
    repeat (4) @(negedge clk);
    ce = 1;
    @(negedge clk);
    hv_oe = 0;
  endtask

  task automatic wait_ready(input int limit);
    int n = 0;
    while (pull && n < limit) begin
      @(negedge clk);
      n++;
    end
    if (pull) chk("R5 ready timeout", 1, 0);
    repeat (2) @(negedge clk);
  endtask

  logic [7:0] ref_mem [2**AW];
  logic [AW-1:0] hist [24];

  initial begin
    logic [7:0] v;
    logic en;
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 bus released", int'(doe), 0);
    chk("R11 ready released", int'(pull), 0);

    // supply low, then lockout
    busy_seen = 0;
    wr(13'h0100, 8'h5A, 0);
    chk("R7 write with supply low", int'(busy_seen), 0);
    vdd_ok = 1;
    busy_seen = 0;
    wr(13'h0100, 8'h5A, 0);
    chk("R7 write in lockout", int'(busy_seen), 0);
    repeat (PON + 10) @(negedge clk);
    busy_seen = 0;
    wr(13'h0100, 8'h5A, 0);
    chk("R5 busy pulled", int'(busy_seen), 1);
    wait_ready(200);
    chk("R3 busy length", last_len, WR + 1);
    rd(13'h0100, v, en);
    chk("R2 readback", int'(v), 8'h5A);
    chk("R1 bus driven on read", int'(en), 1);
    vdd_ok = 0;
    busy_seen = 0;
    wr(13'h0100, 8'hA5, 0);
    chk("R7 no busy supply dropped", int'(busy_seen), 0);
    rd(13'h0100, v, en);
    chk("R7 byte kept", int'(v), 8'h5A);
    vdd_ok = 1;
    repeat (PON + 10) @(negedge clk);

    // data polling
    wr(13'h0200, 8'h3C, 0);
    rd(13'h0555, v, en);
    chk("R4 poll bit7 of 0x3C", int'(v), 8'h80);
    chk("R4 poll drives bus", int'(en), 1);
    wait_ready(200);
    rd(13'h0200, v, en);
    chk("R3 true data after write", int'(v), 8'h3C);
    wr(13'h0201, 8'hC3, 0);
    rd(13'h0200, v, en);
    chk("R4 poll bit7 of 0xC3", int'(v), 8'h00);
    wait_ready(200);
    rd(13'h0201, v, en);
    chk("R3 true data 0xC3", int'(v), 8'hC3);

    // output-enable low blocks writing
    busy_seen = 0;
    wr(13'h0100, 8'h11, 2);
    chk("R6 no busy oe low", int'(busy_seen), 0);
    rd(13'h0100, v, en);
    chk("R6 byte kept", int'(v), 8'h5A);

    // strobe during busy
    wr(13'h0300, 8'h21, 0);
    wr(13'h0100, 8'h99, 0);
    wait_ready(200);
    rd(13'h0100, v, en);
    chk("R8 second write ignored", int'(v), 8'h5A);
    rd(13'h0300, v, en);
    chk("R8 first write done", int'(v), 8'h21);

    // chip-enable controlled, address early, data late
    wr(13'h0400, 8'h66, 1);
    wait_ready(200);
    rd(13'h0400, v, en);
    chk("R2 ce-controlled write", int'(v), 8'h66);
    rd(~13'h0400, v, en);
    chk("R2 late address not used", int'(v), int'(ref_mem[~13'h0400]));

    // identification area
    wr(13'h1FE3, 8'h11, 0);
    wait_ready(200);
    hv_id = 1;
    wr(13'h1FE3, 8'h77, 0);
    wait_ready(200);
    rd(13'h1FE3, v, en);
    chk("R9 id area read", int'(v), 8'h77);
    rd(13'h0100, v, en);
    chk("R9 low address main with flag", int'(v), 8'h5A);
    hv_id = 0;
    rd(13'h1FE3, v, en);
    chk("R9 main array at id address", int'(v), 8'h11);

    // read gating
    @(negedge clk); ce = 1; oe = 0; we = 1;
    repeat (5) @(negedge clk);
    chk("R1 ce high no drive", int'(doe), 0);
    ce = 0; oe = 0; we = 0; din = 8'h00; addr = 13'h0100;
    repeat (3) @(negedge clk);
    chk("R1 we low no drive", int'(doe), 0);
    @(negedge clk); ce = 1; oe = 1; we = 1;
    repeat (6) @(negedge clk);

    // random writes with polling checks
    ref_mem[13'h0100] = 8'h5A;
    ref_mem[13'h0400] = 8'h66;
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom % 8000);
      d = 8'($urandom);
      hist[i] = a;
      wr(a, d, int'($urandom % 2));
      rd(AW'($urandom), v, en);
      chk("R4 random poll", int'(v), int'({~d[7], 7'd0}));
      wait_ready(200);
      chk("R3 random busy length", last_len, WR + 1);
      ref_mem[a] = d;
      rd(hist[$urandom % (i + 1)], v, en);
      chk("R2 random readback", int'(v), int'(ref_mem[addr]));
    end

    // chip clear
    busy_seen = 0;
    clr_pulse(CLRP - 6);
    chk("R10 short pulse no busy", int'(busy_seen), 0);
    rd(hist[0], v, en);
    chk("R10 short pulse keeps data", int'(v), int'(ref_mem[hist[0]]));
    clr_pulse(CLRP + 6);
    wait_ready(20000);
    chk("R10 clear busy length", last_len, 2 ** AW);
    for (int i = 0; i < 6; i++) begin
      rd(hist[i * 4], v, en);
      chk("R10 cleared byte", int'(v), 8'hFF);
    end
    rd(13'h0400, v, en);
    chk("R10 cleared 0x0400", int'(v), 8'hFF);
    hv_id = 1;
    rd(13'h1FE3, v, en);
    chk("R10 id area untouched", int'(v), 8'h77);
    hv_id = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule